// File: doc/BRIEF.md
# Packed SIMD Bit-Manipulation ALU

This unit runs one bit-manipulation operation per accepted request across a 64-bit packed operand. A two-bit width code splits the operand into elements of 8, 16, 32 or 64 bits, and every element is processed independently. The first operand is always a packed vector. The second operand is either a packed vector or a scalar whose low element-sized slice is copied to every element. An immediate rotate amount is supplied the same way as a scalar.

The operations are rotate left and right, and-not, three reversals, leading and trailing zero counts, population count, and a widening shift. The reversals are bits inside each byte, bytes inside each element, and all bits of an element. The widening shift turns every source element into a double-width result element, which is why the result register is twice the datapath width. The result is registered, so a request presented with `in_valid` appears one clock later with `out_valid`. A pairing of opcode and width that the unit cannot perform returns zero and raises `illegal`.

Top module: `simd_bitmanip_alu`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high and low otherwise. A synchronous reset clears `out_valid`, `illegal` and `result`.
- R2: Width code `sew` selects the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Rotate left (`op_code` 0) and rotate right (`op_code` 1) rotate each element of A by the matching element of B taken modulo the element width.
- R3: With `b_scalar` = 1, the low element-width bits of `op_b` are used as B for every element. With `b_scalar` = 0, element i of B is `op_b[W*(i+1)-1 : W*i]`.
- R4: And-not (`op_code` 2) returns A AND NOT B for each element.
- R5: Bit reverse in byte (`op_code` 3) reverses the 8 bits of every byte and keeps byte order, at any width.
- R6: Byte reverse (`op_code` 4) reverses byte order inside each element. At 8-bit width the result equals A.
- R7: Bit reverse (`op_code` 5) reverses all bits of each element.
- R8: Count leading zeros (`op_code` 6) and count trailing zeros (`op_code` 7) give the count for each element, and give the element width for an all-zero element.
- R9: Population count (`op_code` 8) gives the number of set bits of each element, zero-extended to the element width.
- R10: Widening shift (`op_code` 9) takes source elements of 8, 16 or 32 bits from all 64 bits of A and B. It zero-extends each to twice its width, shifts it left by B masked to log2(2W) bits, and places element i at `result[2W*(i+1)-1 : 2W*i]`.
- R11: For every non-widening operation the result occupies `result[63:0]` and `result[127:64]` is zero.
- R12: `op_code` values 10 to 15, and the widening shift at width code 3, give a zero result with `illegal` high alongside `out_valid`. `illegal` is low in any other cycle.
- R13: While `in_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Operation select |
| sew | input | 2 | Element width code |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B or scalar |
| b_scalar | input | 1 | Broadcast low slice of op_b to all elements |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result |
| illegal | output | 1 | Unsupported opcode and width pairing |

## Verification
Rotates are tried with amounts of zero, inside the element width and at or above it. This separates a correct modulo from a plain shift and from a wrong amount width, and vector and scalar B are both used so a broken broadcast shows. Counts are tried on all-zero, all-one and single-bit elements, which exposes off-by-one limits. The widening shift is tried with amounts that need the extra mask bit, and with sources in the upper half of A, which checks masking and placement. A long stream of pseudo-random operands over every opcode and width, issued back to back, catches cross-element leakage and pipeline slips.

// File: rtl/simd_bm_pkg.sv
package simd_bm_pkg;
  typedef enum logic [3:0] {
    BM_ROL   = 4'd0,
    BM_ROR   = 4'd1,
    BM_ANDN  = 4'd2,
    BM_BREV8 = 4'd3,
    BM_REV8  = 4'd4,
    BM_BREV  = 4'd5,
    BM_CLZ   = 4'd6,
    BM_CTZ   = 4'd7,
    BM_CPOP  = 4'd8,
    BM_WSLL  = 4'd9
  } bm_op_e;

  localparam logic [3:0] BM_LAST_OP = 4'd9;
  localparam int         NUM_SEW    = 4;
  localparam logic [1:0] SEW_64     = 2'd3;
endpackage

// File: rtl/simd_bm_elem.sv
module simd_bm_elem
  import simd_bm_pkg::*;
#(
  parameter int W = 8
) (
  input  bm_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   r
);
  localparam int AW = $clog2(W);
  localparam int CW = AW + 1;
  localparam int NB = W / 8;

  logic [AW-1:0]  amt;
  logic [2*W-1:0] rl, rr;
  logic [CW-1:0]  lz, tz, pop;
  logic           hit_l, hit_t;
  logic [W-1:0]   rbit, rb8, rv8;

  always_comb begin
    amt = b[AW-1:0];
    rl  = {a, a} << amt;
    rr  = {a, a} >> amt;

    lz    = '0;
    hit_l = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit_l) begin
        if (a[i]) hit_l = 1'b1;
        else      lz = lz + CW'(1);
      end
    end

    tz    = '0;
    hit_t = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!hit_t) begin
        if (a[i]) hit_t = 1'b1;
        else      tz = tz + CW'(1);
      end
    end

    pop = '0;
    for (int i = 0; i < W; i++) pop = pop + CW'(a[i]);

    for (int i = 0; i < W; i++) rbit[i] = a[W-1-i];
    for (int i = 0; i < W; i++) rb8[i] = a[(i/8)*8 + 7 - (i%8)];
    for (int k = 0; k < NB; k++) rv8[k*8 +: 8] = a[(NB-1-k)*8 +: 8];

    case (op)
      BM_ROL:   r = rl[2*W-1:W];
      BM_ROR:   r = rr[W-1:0];
      BM_ANDN:  r = a & ~b;
      BM_BREV8: r = rb8;
      BM_REV8:  r = rv8;
      BM_BREV:  r = rbit;
      BM_CLZ:   r = W'(lz);
      BM_CTZ:   r = W'(tz);
      BM_CPOP:  r = W'(pop);
      default:  r = '0;
    endcase
  end
endmodule

// File: rtl/simd_bm_wsll.sv
module simd_bm_wsll #(
  parameter int SW = 8
) (
  input  logic [SW-1:0]            a,
  input  logic [$clog2(2*SW)-1:0]  sh,
  output logic [2*SW-1:0]          r
);
  logic [2*SW-1:0] ext;

  always_comb begin
    ext = {{SW{1'b0}}, a};
    r   = ext << sh;
  end
endmodule

// File: rtl/simd_bitmanip_alu.sv
module simd_bitmanip_alu
  import simd_bm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [3:0]            op_code,
  input  logic [1:0]            sew,
  input  logic [DATA_W-1:0]     op_a,
  input  logic [DATA_W-1:0]     op_b,
  input  logic                  b_scalar,
  output logic                  out_valid,
  output logic [2*DATA_W-1:0]   result,
  output logic                  illegal
);
  localparam int RES_W = 2 * DATA_W;

  bm_op_e              op;
  logic [DATA_W-1:0]   lane_res [NUM_SEW];
  logic [RES_W-1:0]    wide_res [NUM_SEW];
  logic                ill_next;
  logic [RES_W-1:0]    res_next;

  assign op = bm_op_e'(op_code);

  for (genvar gi = 0; gi < NUM_SEW; gi++) begin : g_sew
    localparam int W  = 8 << gi;
    localparam int NE = DATA_W / W;
    if (W <= DATA_W) begin : g_lane
      for (genvar ei = 0; ei < NE; ei++) begin : g_el
        logic [W-1:0] b_el;
        assign b_el = b_scalar ? op_b[W-1:0] : op_b[ei*W +: W];
        simd_bm_elem #(.W(W)) u_elem (
          .op (op),
          .a  (op_a[ei*W +: W]),
          .b  (b_el),
          .r  (lane_res[gi][ei*W +: W])
        );
      end
    end else begin : g_nolane
      assign lane_res[gi] = '0;
    end

    if (2 * W <= DATA_W) begin : g_wide
      localparam int SHW = $clog2(2 * W);
      for (genvar ei = 0; ei < NE; ei++) begin : g_wel
        logic [SHW-1:0] sh_el;
        assign sh_el = b_scalar ? op_b[SHW-1:0] : op_b[ei*W +: SHW];
        simd_bm_wsll #(.SW(W)) u_wsll (
          .a  (op_a[ei*W +: W]),
          .sh (sh_el),
          .r  (wide_res[gi][ei*2*W +: 2*W])
        );
      end
    end else begin : g_nowide
      assign wide_res[gi] = '0;
    end
  end

  always_comb begin
    ill_next = (op_code > BM_LAST_OP) || (op == BM_WSLL && sew == SEW_64);
    if (ill_next)          res_next = '0;
    else if (op == BM_WSLL) res_next = wide_res[sew];
    else                   res_next = {{DATA_W{1'b0}}, lane_res[sew]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_next;
        illegal <= ill_next;
      end else begin
        illegal <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/simd_bm_alu_chk.sv
module simd_bm_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [3:0]          op_code,
  input logic                out_valid,
  input logic [2*DATA_W-1:0] result,
  input logic                illegal
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R12
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0));
  // R12
  illegal_valid_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid);
  // R12
  illegal_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code > 4'd9) |=> illegal);
  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code != 4'd9) |=> (result[2*DATA_W-1:DATA_W] == '0));
  // R13
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

bind simd_bitmanip_alu simd_bm_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_code   (op_code),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/tb_simd_bitmanip_alu.sv
module tb_simd_bitmanip_alu;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [1:0]   sew = '0;
  logic [63:0]  op_a = '0;
  logic [63:0]  op_b = '0;
  logic         b_scalar = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  int n_chk = 0;
  int n_bad = 0;

  logic [127:0] q_res [$];
  logic         q_ill [$];
  string        q_tag [$];
  logic [63:0]  rng = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  simd_bitmanip_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .sew(sew),
    .op_a(op_a), .op_b(op_b), .b_scalar(b_scalar), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  function automatic logic [63:0] wmask(int w);
    return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic void model(input logic [3:0] op, input logic [1:0] s,
                                input logic [63:0] a, input logic [63:0] b,
                                input logic sc, output logic [127:0] r,
                                output logic ill);
    int w;
    logic [63:0] m, ae, be, re;
    logic [127:0] wr;
    int amt, cnt;
    w   = 8 << s;
    m   = wmask(w);
    r   = '0;
    ill = (op > 4'd9) || (op == 4'd9 && s == 2'd3);
    if (ill) return;
    if (op == 4'd9) begin
      for (int e = 0; e < 64 / w; e++) begin
        ae  = (a >> (e * w)) & m;
        be  = sc ? (b & m) : ((b >> (e * w)) & m);
        amt = int'(be & 64'(2 * w - 1));
        wr  = {64'd0, ae} << amt;
        wr  = wr & {64'd0, wmask(2 * w)};
        r   = r | (wr << (e * 2 * w));
      end
      return;
    end
    for (int e = 0; e < 64 / w; e++) begin
      ae = (a >> (e * w)) & m;
      be = sc ? (b & m) : ((b >> (e * w)) & m);
      re = '0;
      amt = int'(be % 64'(w));
      case (op)
        4'd0: re = ((ae << amt) | ((amt == 0) ? 64'd0 : (ae >> (w - amt)))) & m;
        4'd1: re = ((ae >> amt) | ((amt == 0) ? 64'd0 : (ae << (w - amt)))) & m;
        4'd2: re = ae & ~be & m;
        4'd3: for (int i = 0; i < w; i++) re[i] = ae[(i / 8) * 8 + 7 - (i % 8)];
        4'd4: for (int k = 0; k < w / 8; k++)
                for (int j = 0; j < 8; j++) re[k * 8 + j] = ae[(w / 8 - 1 - k) * 8 + j];
        4'd5: for (int i = 0; i < w; i++) re[i] = ae[w - 1 - i];
        4'd6: begin
          cnt = w;
          for (int i = 0; i < w; i++) if (ae[i]) cnt = w - 1 - i;
          re = 64'(cnt);
        end
        4'd7: begin
          cnt = w;
          for (int i = w - 1; i >= 0; i--) if (ae[i]) cnt = i;
          re = 64'(cnt);
        end
        default: begin
          cnt = 0;
          for (int i = 0; i < w; i++) cnt += int'(ae[i]);
          re = 64'(cnt);
        end
      endcase
      r = r | ({64'd0, re} << (e * w));
    end
  endfunction

  task automatic drive(input logic [3:0] op, input logic [1:0] s,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic sc, input string tag);
    logic [127:0] er;
    logic         ei;
    model(op, s, a, b, sc, er, ei);
    q_res.push_back(er);
    q_ill.push_back(ei);
    q_tag.push_back(tag);
    in_valid = 1'b1;
    op_code  = op;
    sew      = s;
    op_a     = a;
    op_b     = b;
    b_scalar = sc;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: compare at the falling edge, away from the capture edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_chk++;
      if (q_res.size() == 0) begin
        n_bad++;
        $display("FAIL R1: unexpected out_valid, actual 1 expected 0");
      end else begin
        logic [127:0] er;
        logic         ei;
        string        tg;
        er = q_res.pop_front();
        ei = q_ill.pop_front();
        tg = q_tag.pop_front();
        if (result !== er || illegal !== ei) begin
          n_bad++;
          $display("FAIL %s: actual %h ill=%b expected %h ill=%b",
                   tg, result, illegal, er, ei);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (out_valid !== 1'b0 || illegal !== 1'b0 || result !== '0) begin
      n_bad++;
      $display("FAIL R1: reset state actual v=%b i=%b r=%h expected 0 0 0",
               out_valid, illegal, result);
    end
    rst = 1'b0;
    idle(1);

    // R2 rotates, amounts 0, in range, and at or above the width
    drive(4'd0, 2'd0, 64'h8001_4002_F00F_0180, 64'h0009_0001_0403_0800, 1'b0, "R2 rol8");
    drive(4'd1, 2'd1, 64'h8001_4002_F00F_0180, 64'h0010_0001_0014_000F, 1'b0, "R2 ror16");
    drive(4'd0, 2'd2, 64'h8000_0001_1234_5678, 64'h0000_0021_0000_0004, 1'b0, "R2 rol32");
    drive(4'd1, 2'd3, 64'h0123_4567_89AB_CDEF, 64'd68, 1'b0, "R2 ror64");
    // R3 scalar broadcast; upper op_b bits must not matter
    drive(4'd1, 2'd0, 64'h0102_0408_1020_4080, 64'hFFFF_FFFF_FFFF_FF03, 1'b1, "R3 ror8 scalar");
    drive(4'd2, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_0F0F, 1'b1, "R3 andn16 scalar");
    // R4
    drive(4'd2, 2'd2, 64'hF0F0_F0F0_AAAA_5555, 64'hFF00_00FF_0F0F_FFFF, 1'b0, "R4 andn32");
    // R5, R6, R7
    drive(4'd3, 2'd1, 64'h0180_F001_1234_C3A5, 64'd0, 1'b0, "R5 brev8");
    drive(4'd4, 2'd0, 64'h0011_2233_4455_6677, 64'd0, 1'b0, "R6 rev8 identity");
    drive(4'd4, 2'd2, 64'h0011_2233_4455_6677, 64'd0, 1'b0, "R6 rev8_32");
    drive(4'd5, 2'd3, 64'h0000_0000_0000_0001, 64'd0, 1'b0, "R7 brev64");
    // R8 counts incl. all-zero elements
    drive(4'd6, 2'd0, 64'h0001_8040_0020_FF00, 64'd0, 1'b0, "R8 clz8");
    drive(4'd6, 2'd2, 64'h0000_0000_0000_8000, 64'd0, 1'b0, "R8 clz32");
    drive(4'd7, 2'd1, 64'h0000_8000_0001_0010, 64'd0, 1'b0, "R8 ctz16");
    drive(4'd7, 2'd3, 64'd0, 64'd0, 1'b0, "R8 ctz64 zero");
    // R9
    drive(4'd8, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, "R9 cpop64");
    drive(4'd8, 2'd0, 64'h0001_0307_0F1F_3F7F, 64'd0, 1'b0, "R9 cpop8");
    // R10 widening shift, amount needs the extra mask bit, upper-half sources
    drive(4'd9, 2'd0, 64'hFF81_0000_0000_00FF, 64'h0F1F_0000_0000_0008, 1'b0, "R10 wsll8");
    drive(4'd9, 2'd1, 64'h8001_0000_FFFF_1234, 64'h0000_0000_0000_0011, 1'b1, "R10 wsll16 scalar");
    drive(4'd9, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_007F_0000_003F, 1'b0, "R10 wsll32");
    // R12 illegal pairings
    drive(4'd9, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R12 wsll64");
    drive(4'd12, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, "R12 op12");
    idle(2);

    // R13 hold with no request
    held = result;
    idle(3);
    n_chk++;
    if (result !== held || out_valid !== 1'b0 || illegal !== 1'b0) begin
      n_bad++;
      $display("FAIL R13: actual %h v=%b i=%b expected %h v=0 i=0",
               result, out_valid, illegal, held);
    end

    // R11 and all ops: back-to-back pseudo-random stream
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ra, rb;
      logic [3:0]  rop;
      ra  = next_rand();
      rb  = next_rand();
      rop = 4'(k % 11);
      drive(rop, 2'(k / 11), ra, rb, rb[0], "R11 random");
    end
    idle(3);

    n_chk++;
    if (q_res.size() != 0) begin
      n_bad++;
      $display("FAIL R1: pending results actual %0d expected 0", q_res.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule